// File: doc/BRIEF.md
# Destination Register Update Combiner

This block sits on the path into a register file write port. Each instruction result, or each word returned by a load, is folded into the current contents of its destination register before it is written back. A 3-bit update mode travels with the instruction and selects the fold. It can be a plain overwrite, a bitwise merge (XOR, AND, OR, AND-NOT), a complement of the result, or an arithmetic merge (add, subtract, reverse subtract). The old destination value is read alongside the new result, and the combined value is what the register file stores.

A 64-bit load writes a register pair. In the arithmetic modes the two 32-bit halves form a single 64-bit operation: carry or borrow passes from the low register to the high one. In the bitwise modes each half is combined on its own. A class input gives mode code 110 two meanings. For load and arithmetic instructions it is a reverse subtract. For bitwise instructions it is AND-NOT.

The block is purely combinational and has no clock, reset or handshake. It adds no cycle and holds no state. Any stall or flow control belongs to the pipeline around it.

Top module: `dest_upd_combiner`

## Requirements
- R1: Mode 000 writes the new result unchanged (`out_lo = new_lo`, and `out_hi = new_hi` on a pair).
- R2: Mode 001 writes old XOR new.
- R3: Mode 010 writes the bitwise complement of the new result. The old register value has no effect on the output.
- R4: Mode 100 writes old AND new. Mode 101 writes old OR new.
- R5: Mode 011 on a single write (`pair_wr = 0`) writes `(old + new) mod 2^32`, with no carry in.
- R6: Mode 011 on a pair (`pair_wr = 1`) writes the 64-bit sum `{cur_hi,cur_lo} + {new_hi,new_lo}`. The high half is an add-with-carry that uses the carry out of the low half.
- R7: Mode 111 writes old minus new. On a single write this is modulo 2^32. On a pair the borrow from the low half is taken in the high half, giving a 64-bit difference.
- R8: Mode 110 with `bitwise_cls = 0` (load or arithmetic class) writes new minus old. On a pair the borrow chains, as in R7.
- R9: Mode 110 with `bitwise_cls = 1` (bitwise class) writes old AND (NOT new).
- R10: In the bitwise modes (000, 001, 010, 100, 101, and 110 with the bitwise class), a pair write combines each half independently, with nothing passing between the halves.
- R11: With `pair_wr = 0`, `out_hi` is zero whatever `cur_hi` and `new_hi` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_lo | input | 32 | Current value of the (low) destination register |
| cur_hi | input | 32 | Current value of the high register of a pair |
| new_lo | input | 32 | New result for the (low) destination register |
| new_hi | input | 32 | New result for the high register of a pair |
| upd_mode | input | 3 | Update mode code (encodings as in R1 to R9) |
| pair_wr | input | 1 | 1 = 64-bit pair write, 0 = single 32-bit write |
| bitwise_cls | input | 1 | 1 = bitwise instruction class, 0 = load or arithmetic class |
| out_lo | output | 32 | Value to write to the (low) destination register |
| out_hi | output | 32 | Value to write to the high register (zero unless pair) |

## Verification
Immediate assertions are evaluated whenever an input changes. They check that the high half is zero on single writes, that the three pair arithmetic modes equal a true 64-bit add or subtract including the carry out of the top, and that the complement and AND-NOT lanes hold their bit relations. Those assertions cannot show that the single-write arithmetic modes drop the carry, which bitwise mode each code selects, or that a pair in a bitwise mode keeps its halves apart. The bench's vector table and its pseudo-random sweep against an independent 64-bit model cover those cases, together with the carry and borrow rippling through all 64 bits.

// File: rtl/dest_upd_pkg.sv
package dest_upd_pkg;

  typedef enum logic [2:0] {
    UPD_PASS = 3'b000,
    UPD_XOR  = 3'b001,
    UPD_NOT  = 3'b010,
    UPD_ADD  = 3'b011,
    UPD_AND  = 3'b100,
    UPD_OR   = 3'b101,
    UPD_REV  = 3'b110,
    UPD_SUB  = 3'b111
  } upd_mode_e;

  typedef enum logic [1:0] {
    AR_ADD  = 2'd0,
    AR_SUB  = 2'd1,
    AR_RSUB = 2'd2
  } arith_op_e;

  // Arithmetic path is used for add, sub, and code 110 outside the bitwise class
  function automatic logic mode_is_arith(upd_mode_e m, logic bw);
    return (m == UPD_ADD) || (m == UPD_SUB) || ((m == UPD_REV) && !bw);
  endfunction

  function automatic arith_op_e arith_op_of(upd_mode_e m);
    case (m)
      UPD_ADD: return AR_ADD;
      UPD_SUB: return AR_SUB;
      default: return AR_RSUB;
    endcase
  endfunction

endpackage

// File: rtl/upd_arith_lane.sv
module upd_arith_lane
  import dest_upd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] cur,
  input  logic [WORD_W-1:0] nxt,
  input  arith_op_e         op,
  input  logic              cin,
  output logic [WORD_W-1:0] sum,
  output logic              cout
);

  logic [WORD_W-1:0] opa;
  logic [WORD_W-1:0] opb;

  // Subtraction is an add of the inverted subtrahend; borrow = ~carry
  always_comb begin
    case (op)
      AR_ADD: begin
        opa = cur;
        opb = nxt;
      end
      AR_SUB: begin
        opa = cur;
        opb = ~nxt;
      end
      default: begin
        opa = nxt;
        opb = ~cur;
      end
    endcase
  end

  assign {cout, sum} = {1'b0, opa} + {1'b0, opb} + {{WORD_W{1'b0}}, cin};

endmodule

// File: rtl/upd_logic_lane.sv
module upd_logic_lane
  import dest_upd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] cur,
  input  logic [WORD_W-1:0] nxt,
  input  upd_mode_e         mode,
  output logic [WORD_W-1:0] res
);

  always_comb begin
    case (mode)
      UPD_PASS: res = nxt;
      UPD_XOR:  res = cur ^ nxt;
      UPD_NOT:  res = ~nxt;
      UPD_AND:  res = cur & nxt;
      UPD_OR:   res = cur | nxt;
      UPD_REV:  res = cur & ~nxt;
      default:  res = nxt;
    endcase
  end

  always_comb begin
    if (mode == UPD_NOT) begin
      // R3
      not_complement_chk: assert ((res ^ nxt) == {WORD_W{1'b1}})
        else $error("NOT lane does not complement the result");
    end
    if (mode == UPD_REV) begin
      // R9
      andnot_subset_chk: assert (((res & nxt) == '0) && ((res & ~cur) == '0))
        else $error("AND-NOT lane sets a bit outside old & ~new");
    end
  end

endmodule

// File: rtl/dest_upd_combiner.sv
module dest_upd_combiner
  import dest_upd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] cur_lo,
  input  logic [WORD_W-1:0] cur_hi,
  input  logic [WORD_W-1:0] new_lo,
  input  logic [WORD_W-1:0] new_hi,
  input  logic [2:0]        upd_mode,
  input  logic              pair_wr,
  input  logic              bitwise_cls,
  output logic [WORD_W-1:0] out_lo,
  output logic [WORD_W-1:0] out_hi
);

  localparam int LANES = 2;
  localparam int DW    = LANES * WORD_W;

  upd_mode_e mode;
  arith_op_e aop;
  logic      use_arith;

  assign mode      = upd_mode_e'(upd_mode);
  assign aop       = arith_op_of(mode);
  assign use_arith = mode_is_arith(mode, bitwise_cls);

  logic [WORD_W-1:0] cur_l   [LANES];
  logic [WORD_W-1:0] nxt_l   [LANES];
  logic [WORD_W-1:0] arith_l [LANES];
  logic [WORD_W-1:0] logic_l [LANES];
  logic [WORD_W-1:0] lane_o  [LANES];
  logic [LANES:0]    carry;
  logic [LANES-1:0]  lane_cin;

  assign cur_l[0] = cur_lo;
  assign cur_l[1] = cur_hi;
  assign nxt_l[0] = new_lo;
  assign nxt_l[1] = new_hi;

  // Subtract forms inject +1 at the chain base
  assign carry[0] = (aop != AR_ADD);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_base
      assign lane_cin[g] = carry[0];
    end else begin : g_chain
      assign lane_cin[g] = pair_wr ? carry[g] : carry[0];
    end

    upd_arith_lane #(.WORD_W(WORD_W)) u_arith (
      .cur  (cur_l[g]),
      .nxt  (nxt_l[g]),
      .op   (aop),
      .cin  (lane_cin[g]),
      .sum  (arith_l[g]),
      .cout (carry[g+1])
    );

    upd_logic_lane #(.WORD_W(WORD_W)) u_logic (
      .cur  (cur_l[g]),
      .nxt  (nxt_l[g]),
      .mode (mode),
      .res  (logic_l[g])
    );

    assign lane_o[g] = use_arith ? arith_l[g] : logic_l[g];
  end

  assign out_lo = lane_o[0];
  assign out_hi = pair_wr ? lane_o[1] : '0;

  logic [DW-1:0] cur_w;
  logic [DW-1:0] new_w;
  logic [DW-1:0] out_w;
  assign cur_w = {cur_hi, cur_lo};
  assign new_w = {new_hi, new_lo};
  assign out_w = {out_hi, out_lo};

  always_comb begin
    if (!pair_wr) begin
      // R11
      hi_zero_chk: assert (out_hi == '0)
        else $error("high half not zero on a single write");
    end
    if (pair_wr && (mode == UPD_ADD)) begin
      // R6
      pair_add_chk: assert ({carry[LANES], out_w} == ({1'b0, cur_w} + {1'b0, new_w}))
        else $error("pair add differs from 64-bit sum");
    end
    if (pair_wr && (mode == UPD_SUB)) begin
      // R7
      pair_sub_chk: assert (out_w == (cur_w - new_w))
        else $error("pair subtract differs from 64-bit difference");
    end
    if (pair_wr && (mode == UPD_REV) && !bitwise_cls) begin
      // R8
      pair_rsub_chk: assert (out_w == (new_w - cur_w))
        else $error("pair reverse subtract differs from 64-bit difference");
    end
  end

endmodule

// File: tb/dest_upd_combiner_tb.sv
module dest_upd_combiner_tb;

  logic        clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] cur_lo, cur_hi, new_lo, new_hi;
  logic [2:0]  upd_mode;
  logic        pair_wr, bitwise_cls;
  logic [31:0] out_lo, out_hi;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  dest_upd_combiner u_dut (
    .cur_lo(cur_lo), .cur_hi(cur_hi), .new_lo(new_lo), .new_hi(new_hi),
    .upd_mode(upd_mode), .pair_wr(pair_wr), .bitwise_cls(bitwise_cls),
    .out_lo(out_lo), .out_hi(out_hi)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  m;
    logic        p;
    logic        bw;
    logic [31:0] ol, oh, nl, nh, el, eh;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1,  3'b000, 1'b0, 1'b0, 32'h12345678, 32'h0, 32'h000000FF, 32'h0, 32'h000000FF, 32'h0},        // R1
    '{4'd2,  3'b001, 1'b0, 1'b0, 32'hFF00FF00, 32'h0, 32'h0F0F0F0F, 32'h0, 32'hF00FF00F, 32'h0},        // R2
    '{4'd3,  3'b010, 1'b0, 1'b0, 32'hDEADBEEF, 32'h0, 32'h0000FFFF, 32'h0, 32'hFFFF0000, 32'h0},        // R3
    '{4'd5,  3'b011, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h7, 32'h00000001, 32'h9, 32'h00000000, 32'h0},        // R5, R11
    '{4'd6,  3'b011, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h1, 32'h00000001, 32'h2, 32'h00000000, 32'h4},        // R6
    '{4'd4,  3'b100, 1'b0, 1'b1, 32'hF0F0F0F0, 32'h0, 32'hFF00FF00, 32'h0, 32'hF000F000, 32'h0},        // R4
    '{4'd10, 3'b101, 1'b1, 1'b1, 32'h0000000F, 32'hF0, 32'h000000F0, 32'hF00, 32'h000000FF, 32'hFF0},   // R10
    '{4'd7,  3'b111, 1'b0, 1'b0, 32'h00000005, 32'h0, 32'h00000007, 32'h0, 32'hFFFFFFFE, 32'h0},        // R7
    '{4'd7,  3'b111, 1'b1, 1'b0, 32'h00000000, 32'h1, 32'h00000001, 32'h0, 32'hFFFFFFFF, 32'h0},        // R7
    '{4'd8,  3'b110, 1'b0, 1'b0, 32'h00000003, 32'h0, 32'h0000000A, 32'h0, 32'h00000007, 32'h0},        // R8
    '{4'd8,  3'b110, 1'b1, 1'b0, 32'h00000001, 32'h0, 32'h00000000, 32'h5, 32'hFFFFFFFF, 32'h4},        // R8
    '{4'd9,  3'b110, 1'b0, 1'b1, 32'hFFFF0000, 32'h0, 32'h0F0F0F0F, 32'h0, 32'hF0F00000, 32'h0},        // R9
    '{4'd10, 3'b110, 1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFF, 32'h00000000, 32'hF, 32'hFFFFFFFF, 32'hFFF0},  // R10
    '{4'd10, 3'b010, 1'b1, 1'b0, 32'h12345678, 32'h9, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0}, // R10
    '{4'd10, 3'b001, 1'b1, 1'b1, 32'h00000001, 32'h1, 32'h00000001, 32'h1, 32'h00000000, 32'h0}         // R10
  };

  task automatic apply(input logic [2:0] m, input logic p, input logic bw,
                       input logic [31:0] ol, input logic [31:0] oh,
                       input logic [31:0] nl, input logic [31:0] nh);
    @(negedge clk);
    upd_mode = m; pair_wr = p; bitwise_cls = bw;
    cur_lo = ol; cur_hi = oh; new_lo = nl; new_hi = nh;
    #5;
  endtask

  task automatic check(input int req, input logic [31:0] el, input logic [31:0] eh);
    checks++;
    if (out_lo !== el || out_hi !== eh) begin
      failures++;
      $display("FAIL R%0d mode=%b pair=%b bw=%b actual=%h_%h expected=%h_%h",
               req, upd_mode, pair_wr, bitwise_cls, out_hi, out_lo, eh, el);
    end
  endtask

  // Reference built from the requirement text
  function automatic logic [63:0] model(input logic [2:0] m, input logic p, input logic bw,
                                        input logic [63:0] o, input logic [63:0] n);
    logic [63:0] r;
    case (m)
      3'b000: r = n;
      3'b001: r = o ^ n;
      3'b010: r = ~n;
      3'b100: r = o & n;
      3'b101: r = o | n;
      3'b011: r = p ? o + n : {32'h0, o[31:0] + n[31:0]};
      3'b111: r = p ? o - n : {32'h0, o[31:0] - n[31:0]};
      default: r = bw ? (o & ~n) : (p ? n - o : {32'h0, n[31:0] - o[31:0]});
    endcase
    if (!p) r[63:32] = 32'h0;
    return r;
  endfunction

  function automatic int req_of(input logic [2:0] m, input logic p, input logic bw);
    case (m)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 3;
      3'b011: return p ? 6 : 5;
      3'b111: return 7;
      3'b110: return bw ? 9 : 8;
      default: return 4;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] s;
    logic [63:0] o64, n64, e;
    // Idle inputs: all zero gives zero (R1, R11)
    apply(3'b000, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
    check(1, 32'h0, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].m, VECS[i].p, VECS[i].bw, VECS[i].ol, VECS[i].oh, VECS[i].nl, VECS[i].nh);
      check(int'(VECS[i].req), VECS[i].el, VECS[i].eh);
    end

    // R6: carry ripples across all 64 bits
    apply(3'b011, 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h1, 32'h0);
    check(6, 32'h0, 32'h0);
    // R7: borrow ripples across all 64 bits
    apply(3'b111, 1'b1, 1'b0, 32'h0, 32'h0, 32'h1, 32'h0);
    check(7, 32'hFFFFFFFF, 32'hFFFFFFFF);
    // R8: reverse borrow, single write keeps high zero
    apply(3'b110, 1'b0, 1'b0, 32'h1, 32'h5, 32'h0, 32'h3);
    check(8, 32'hFFFFFFFF, 32'h0);
    // R3: old value has no effect
    apply(3'b010, 1'b1, 1'b0, 32'hAAAA5555, 32'h0F0F0F0F, 32'h00FF00FF, 32'h1);
    check(3, 32'hFF00FF00, 32'hFFFFFFFE);
    apply(3'b010, 1'b1, 1'b0, 32'h0, 32'hFFFFFFFF, 32'h00FF00FF, 32'h1);
    check(3, 32'hFF00FF00, 32'hFFFFFFFE);
    // R9 versus R8: same code, class bit flips meaning
    apply(3'b110, 1'b0, 1'b1, 32'h0000000A, 32'h0, 32'h00000003, 32'h0);
    check(9, 32'h00000008, 32'h0);
    // R11: pass-through on single write hides high result
    apply(3'b000, 1'b0, 1'b0, 32'h1, 32'hFFFFFFFF, 32'h2, 32'hFFFFFFFF);
    check(11, 32'h2, 32'h0);

    s = 64'h9E3779B97F4A7C15;
    for (int k = 0; k < 400; k++) begin
      s ^= s << 13; s ^= s >> 7; s ^= s << 17;
      o64 = s;
      s ^= s << 13; s ^= s >> 7; s ^= s << 17;
      n64 = s;
      apply(s[2:0] ^ s[45:43], s[20], s[33], o64[31:0], o64[63:32], n64[31:0], n64[63:32]);
      e = model(upd_mode, pair_wr, bitwise_cls, o64, n64);
      check(req_of(upd_mode, pair_wr, bitwise_cls), e[31:0], e[63:32]);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule